// File: doc/BRIEF.md
# Burst-Mode Tracking Memory Slave

This block is the memory side of an interruptible burst-mode byte-wide memory bus. The bus has eleven wires: an 8-bit data path and a 3-bit cycle-type code. A memory device on this bus does not receive an address with each instruction byte. Instead it keeps its own copy of the processor's program counter. The processor loads a new program address after reset or on a branch. From then on, each instruction-read cycle returns the byte at the tracked address and advances the copy by one.

A second register, the data address, serves data traffic. The processor can load it and then read or write bytes at any point in the instruction burst. Data cycles never touch the program counter copy, so the instruction stream resumes at the right byte without the address being sent again. Both 16-bit addresses are sent as two byte transfers, low byte first. Each data byte moves the data address on by one, so a word is two back-to-back data transfers, low byte first. The storage is a small internal RAM that decodes only the low address bits.

Top module: `trackMemSlave`

## Requirements
- R1: After reset the program counter copy is 0x2000, the data address is 0x0000, both address-load sequences expect their low byte, and `busOutValid` is 0.
- R2: Cycle code 1 loads the program counter copy in two transfers: the first carries the low byte, the second carries the high byte. The new address takes effect only after the high byte.
- R3: Cycle code 3 (instruction read) returns the byte at the program counter copy on `busOut` with `busOutValid` high, in the cycle after the request. The copy then advances by one.
- R4: Cycle code 5 (data write) stores `busIn` at the data address. The data address then advances by one.
- R5: Cycle code 4 (data read) returns the byte at the data address one cycle after the request, with `busOutValid` high. The data address then advances by one, so two consecutive reads return a word, low byte first.
- R6: Data reads, data writes and data-address loads leave the program counter copy unchanged. The next instruction read continues from where the stream stopped.
- R7: Cycle code 2 loads the data address as two transfers, low byte first. Other cycle types that fall between the two halves of either address load are carried out normally and do not disturb the half-finished load.
- R8: Cycle code 0 (idle) and the unused codes 6 and 7 change no state. In the cycle that follows them, `busOutValid` is 0.
- R9: The RAM decodes only the low MEM_AW address bits (8 by default). Address 0x2000 therefore reaches RAM byte 0x00, and 0x2140 reaches byte 0x40.
- R10: Both address registers are 16 bits wide and wrap from 0xFFFF to 0x0000 when they advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cycType | input | 3 | Cycle-type code: 0 idle, 1 load PC, 2 load data address, 3 instruction read, 4 data read, 5 data write, 6/7 unused |
| busIn | input | 8 | Byte driven by the processor (address halves or write data) |
| busOut | output | 8 | Byte returned by the memory for read cycles |
| busOutValid | output | 1 | High in the cycle after an instruction or data read |

## Verification
The RAM is first filled through data writes with an address-dependent pattern. That makes every returned byte identify the address it came from. Runs of plain instruction reads show that the counter steps by one. Branch loads show that the new address takes effect only after its high byte. Data words inserted into a burst, and a data read or instruction read placed between the two halves of a program-address load, separate the two address registers and show that a half-finished load is kept. Idle and unused codes sent with junk data, write-then-read patterns, and loads of 0xFFFF check that nothing happens on idle, that the high address bits are ignored and that the registers wrap.

// File: rtl/trackMemPkg.sv
package trackMemPkg;

  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,
    CYC_LOAD_PC = 3'd1,
    CYC_LOAD_DA = 3'd2,
    CYC_INST_RD = 3'd3,
    CYC_DATA_RD = 3'd4,
    CYC_DATA_WR = 3'd5,
    CYC_RSV6    = 3'd6,
    CYC_RSV7    = 3'd7
  } cycType_e;

  // strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic pcLoadLo;
    logic pcLoadHi;
    logic daLoadLo;
    logic daLoadHi;
    logic instRead;
    logic dataRead;
    logic dataWrite;
  } dpStrobe_t;

endpackage

// File: rtl/trackCtrl.sv
module trackCtrl
  import trackMemPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cycType,
  output dpStrobe_t  strobe
);

  logic pcPhase;  // 1: next LOAD_PC transfer is the high byte
  logic daPhase;  // 1: next LOAD_DA transfer is the high byte

  always_comb begin
    strobe = '0;
    case (cycType)
      CYC_LOAD_PC: begin
        if (pcPhase) strobe.pcLoadHi = 1'b1;
        else         strobe.pcLoadLo = 1'b1;
      end
      CYC_LOAD_DA: begin
        if (daPhase) strobe.daLoadHi = 1'b1;
        else         strobe.daLoadLo = 1'b1;
      end
      CYC_INST_RD: strobe.instRead  = 1'b1;
      CYC_DATA_RD: strobe.dataRead  = 1'b1;
      CYC_DATA_WR: strobe.dataWrite = 1'b1;
      default:     strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcPhase <= 1'b0;
      daPhase <= 1'b0;
    end else begin
      if (cycType == CYC_LOAD_PC) pcPhase <= ~pcPhase;
      if (cycType == CYC_LOAD_DA) daPhase <= ~daPhase;
    end
  end

  // R2: a low-byte program load is always followed by a high-byte expectation
  assert_pc_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cycType == CYC_LOAD_PC && !pcPhase) |=> pcPhase);

  // R7: other cycle types keep a half-finished load pending
  assert_load_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cycType != CYC_LOAD_PC && cycType != CYC_LOAD_DA) |=>
      ($stable(pcPhase) && $stable(daPhase)));

endmodule

// File: rtl/trackDatapath.sv
module trackDatapath
  import trackMemPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOutValid
);

  localparam int DEPTH = 1 << MEM_AW;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

  logic [ADDR_W-1:0] pcCopy;
  logic [ADDR_W-1:0] dataAddr;
  logic [DATA_W-1:0] pcLowHold;
  logic [DATA_W-1:0] daLowHold;
  logic [DATA_W-1:0] memArray [DEPTH];
  logic [MEM_AW-1:0] pcIdx;
  logic [MEM_AW-1:0] daIdx;

  assign pcIdx = pcCopy[MEM_AW-1:0];
  assign daIdx = dataAddr[MEM_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcCopy    <= RESET_PC;
      pcLowHold <= '0;
    end else begin
      if (strobe.pcLoadLo) pcLowHold <= busIn;
      if (strobe.pcLoadHi)      pcCopy <= {busIn, pcLowHold};
      else if (strobe.instRead) pcCopy <= pcCopy + ADDR_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataAddr  <= '0;
      daLowHold <= '0;
    end else begin
      if (strobe.daLoadLo) daLowHold <= busIn;
      if (strobe.daLoadHi) dataAddr <= {busIn, daLowHold};
      else if (strobe.dataRead || strobe.dataWrite) dataAddr <= dataAddr + ADDR_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.dataWrite) memArray[daIdx] <= busIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busOut      <= '0;
      busOutValid <= 1'b0;
    end else begin
      busOutValid <= strobe.instRead || strobe.dataRead;
      if (strobe.instRead)      busOut <= memArray[pcIdx];
      else if (strobe.dataRead) busOut <= memArray[daIdx];
    end
  end

  // R3: each instruction byte moves the program counter copy on by one
  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.instRead |=> (pcCopy == $past(pcCopy) + ADDR_ONE));

  // R6: data traffic and data-address loads leave the program counter copy alone
  assert_pc_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataRead || strobe.dataWrite || strobe.daLoadLo || strobe.daLoadHi)
      |=> $stable(pcCopy));

  // R5: each data byte moves the data address on by one
  assert_da_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataRead || strobe.dataWrite) |=> (dataAddr == $past(dataAddr) + ADDR_ONE));

  // R7: instruction reads and program loads leave the data address alone
  assert_da_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.instRead || strobe.pcLoadLo || strobe.pcLoadHi) |=> $stable(dataAddr));

endmodule

// File: rtl/trackMemSlave.sv
module trackMemSlave
  import trackMemPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cycType,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOutValid
);

  dpStrobe_t strobe;

  trackCtrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .cycType (cycType),
    .strobe  (strobe)
  );

  trackDatapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MEM_AW   (MEM_AW),
    .RESET_PC (RESET_PC)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busIn       (busIn),
    .busOut      (busOut),
    .busOutValid (busOutValid)
  );

  // R3/R5: a read request yields a valid byte in the next cycle
  assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cycType == CYC_INST_RD || cycType == CYC_DATA_RD) |=> busOutValid);

  // R8: every non-read cycle leaves the output marked invalid
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cycType != CYC_INST_RD && cycType != CYC_DATA_RD) |=> !busOutValid);

endmodule

// File: tb/trackMemSlave_tb_top.sv
module trackMemSlave_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cycType = 3'd0;
  logic [7:0] busIn = 8'd0;
  logic [7:0] busOut;
  logic       busOutValid;

  int checks = 0;
  int failures = 0;
  logic [7:0] lastOut;
  logic       lastValid;
  logic [7:0] refMem [256];

  always #2.5 clk = ~clk;

  trackMemSlave dut_i (
    .clk(clk), .rstN(rstN), .cycType(cycType), .busIn(busIn),
    .busOut(busOut), .busOutValid(busOutValid)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one bus cycle, result captured just after the edge
  task automatic cyc(input logic [2:0] t, input logic [7:0] d);
    @(negedge clk);
    cycType = t;
    busIn = d;
    @(posedge clk);
    #1;
    lastOut = busOut;
    lastValid = busOutValid;
    @(negedge clk);
    cycType = 3'd0;
    busIn = 8'hEE;
  endtask

  task automatic expectRead(input logic [2:0] t, input logic [7:0] exp, input string tag);
    cyc(t, 8'h00);
    check(lastValid === 1'b1, {tag, " valid"}, int'(lastValid), 1);
    check(lastOut === exp, tag, int'(lastOut), int'(exp));
  endtask

  task automatic loadPc(input logic [15:0] a);
    cyc(3'd1, a[7:0]);
    cyc(3'd1, a[15:8]);
  endtask

  task automatic loadDa(input logic [15:0] a);
    cyc(3'd2, a[7:0]);
    cyc(3'd2, a[15:8]);
  endtask

  task automatic report;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic testReset;
    cyc(3'd0, 8'h00);
    check(lastValid === 1'b0, "R1 valid after reset", int'(lastValid), 0);
  endtask

  task automatic preload;
    loadDa(16'h0000);
    for (int i = 0; i < 256; i++) begin
      refMem[i] = pat(i);
      cyc(3'd5, pat(i));
    end
  endtask

  task automatic testResetStream;
    // R1/R9: reset PC 0x2000 reaches RAM byte 0; R6: preload writes left PC alone
    expectRead(3'd3, refMem[8'h00], "R1 R9 R6 first instr byte");
    expectRead(3'd3, refMem[8'h01], "R3 second instr byte");
    expectRead(3'd3, refMem[8'h02], "R3 third instr byte");
  endtask

  task automatic testBranch;
    loadPc(16'h2140);
    expectRead(3'd3, refMem[8'h40], "R2 R9 branch target");
    expectRead(3'd3, refMem[8'h41], "R3 after branch");
  endtask

  task automatic testInterleaveWord;
    loadDa(16'h0010);
    expectRead(3'd4, refMem[8'h10], "R5 word low byte");
    expectRead(3'd4, refMem[8'h11], "R5 word high byte");
    expectRead(3'd3, refMem[8'h42], "R6 stream resumes");
  endtask

  task automatic testSplitLoad;
    cyc(3'd1, 8'h80);
    expectRead(3'd4, refMem[8'h12], "R7 data read inside PC load");
    expectRead(3'd3, refMem[8'h43], "R2 old PC used before high byte");
    cyc(3'd1, 8'h00);
    expectRead(3'd3, refMem[8'h80], "R7 split PC load completes");
    // split DA load with instruction read between halves
    cyc(3'd2, 8'h20);
    expectRead(3'd3, refMem[8'h81], "R7 instr read inside DA load");
    cyc(3'd2, 8'h00);
    expectRead(3'd4, refMem[8'h20], "R7 split DA load completes");
  endtask

  task automatic testWrite;
    loadDa(16'h0130);
    cyc(3'd5, 8'hA5);
    cyc(3'd5, 8'h5A);
    refMem[8'h30] = 8'hA5;
    refMem[8'h31] = 8'h5A;
    loadDa(16'h0030);
    expectRead(3'd4, 8'hA5, "R4 R9 written low byte");
    expectRead(3'd4, 8'h5A, "R4 written high byte");
    expectRead(3'd3, refMem[8'h82], "R6 stream after writes");
  endtask

  task automatic testIdle;
    cyc(3'd0, 8'h77);
    check(lastValid === 1'b0, "R8 idle no valid", int'(lastValid), 0);
    cyc(3'd6, 8'h55);
    check(lastValid === 1'b0, "R8 code 6 no valid", int'(lastValid), 0);
    cyc(3'd7, 8'h33);
    check(lastValid === 1'b0, "R8 code 7 no valid", int'(lastValid), 0);
    expectRead(3'd3, refMem[8'h83], "R8 PC unchanged by idle");
    expectRead(3'd4, refMem[8'h32], "R8 data address unchanged by idle");
  endtask

  task automatic testWrap;
    loadPc(16'hFFFF);
    expectRead(3'd3, refMem[8'hFF], "R10 PC at 0xFFFF");
    expectRead(3'd3, refMem[8'h00], "R10 PC wraps");
    loadDa(16'hFFFF);
    expectRead(3'd4, refMem[8'hFF], "R10 data address at 0xFFFF");
    expectRead(3'd4, refMem[8'h00], "R10 data address wraps");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    preload();
    testResetStream();
    testBranch();
    testInterleaveWord();
    testSplitLoad();
    testWrite();
    testIdle();
    testWrap();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

endmodule